// File: doc/BRIEF.md
# Host Parallel Port with Bus Holder

This block is the processor-facing side of a display controller. An 8-bit parallel host bus (two chip selects, a data/command select, active-low read and write strobes, and a data bus split into input, output and output-enable) reaches a synchronous display RAM port through one holding register, the bus holder. Every display-data transfer passes through that register. A write posts its byte in the holder, and the holder commits it to RAM in the following system cycle. A read returns what the holder already contains and then refills the holder from RAM at the current address. Because of this, each read returns the byte fetched by the read before it. The host must therefore issue one dummy read after an address change or after a write.

The strobes are sampled in the system clock domain. An access takes effect once, on the rising edge of its strobe. The block decodes two command functions. An address-set command carries the address in its low bits. A status read reports a busy flag on the top data bit. After each accepted write or command, busy stays high for a fixed number of cycles. While busy is high, only status reads are served. The address register advances after each committed write and after each refill, and it wraps at the end of the RAM.

Top module: `hb_host_port`

## Requirements
- R1: The port is selected only while `cs_a_n` is 0 and `cs_b` is 1. When it is not selected, `db_oe` stays 0 and strobe edges have no effect.
- R2: `db_oe` is 1 exactly while the port is selected and `rd_n` is 0.
- R3: A data write (`dc`=1) latches `db_in` into the holder when `wr_n` rises. In the next cycle it pulses `ram_we` for one cycle, with the current address and the holder byte. The address then advances by one.
- R4: A data read returns the holder contents on `db_out`. After `rd_n` rises, the holder is reloaded from RAM at the current address and the address advances by one. The first read after an address set is therefore a dummy read, and the second read returns the byte at the set address.
- R5: The first data read after a data write returns the byte just written.
- R6: A command write (`dc`=0) whose bit DATA_W-1 is 1 loads the address from its low ADDR_W bits. A command write with that bit at 0 leaves the address unchanged.
- R7: `busy` is 1 for exactly BUSY_CYC cycles, starting in the cycle after the `wr_n` rising edge of any accepted write. A status read (`dc`=0, `rd_n`=0) drives `busy` on bit DATA_W-1 and 0 on every other bit.
- R8: While `busy` is 1, writes and data reads are ignored, but status reads are still served.
- R9: Holding a strobe low has no effect until it rises. One write causes exactly one `ram_we` pulse.
- R10: The address wraps from 2**ADDR_W-1 to 0.
- R11: After reset, `busy`, `db_oe`, `ram_we` and `ram_re` are 0, the holder is 0 and the address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| dc | input | 1 | 1 = display data, 0 = command/status |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| db_in | input | DATA_W | Host data bus, input side |
| db_out | output | DATA_W | Host data bus, output side |
| db_oe | output | 1 | Output enable for the host data bus |
| busy | output | 1 | Internal operation in progress |
| ram_addr | output | ADDR_W | Display RAM address |
| ram_we | output | 1 | Display RAM write enable |
| ram_wdata | output | DATA_W | Display RAM write data |
| ram_re | output | 1 | Display RAM read enable, data returned one cycle later |
| ram_rdata | input | DATA_W | Display RAM read data |

## Verification
The bench builds the block with DATA_W=8, ADDR_W=4 and BUSY_CYC=3. With a 16-byte RAM, random traffic crosses the address wrap many times, and the directed wrap case can be reached with a single address set. A busy window of three cycles is long enough to place both a status read and a rejected write inside it, and the bench can still count the exact cycle in which busy falls.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        HB_IDLE    = 2'd0,
        HB_COMMIT  = 2'd1,
        HB_FETCH   = 2'd2,
        HB_CAPTURE = 2'd3
    } hb_phase_e;

    localparam int HB_STB_WR = 0;
    localparam int HB_STB_RD = 1;
    localparam int HB_STB_N  = 2;

endpackage

// File: rtl/hb_strobe_edge.sv
module hb_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = strobe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl_d;
    end

    // A strobe counts as released when it is high now and was low last cycle.
    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise[g] = strobe_n[g] & ~lvl_q[g];
    end
endmodule

// File: rtl/hb_busy_timer.sv
module hb_busy_timer #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(HOLD);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/hb_host_port.sv
module hb_host_port
    import hb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int BUSY_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              dc,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] db_in,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic              busy,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_re,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int FLAG_BIT = DATA_W - 1;

    typedef struct packed {
        hb_phase_e         phase;
        logic [DATA_W-1:0] holder;
        logic [ADDR_W-1:0] addr;
    } hb_regs_t;

    hb_regs_t r_d, r_q;

    logic                selected;
    logic [HB_STB_N-1:0] stb_n;
    logic [HB_STB_N-1:0] stb_rise;
    logic                take_ok;
    logic                wr_take;
    logic                rd_take;

    assign selected = ~cs_a_n & cs_b;

    always_comb begin
        stb_n            = '1;
        stb_n[HB_STB_WR] = wr_n;
        stb_n[HB_STB_RD] = rd_n;
    end

    hb_strobe_edge #(.N(HB_STB_N)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (stb_n),
        .rise     (stb_rise)
    );

    assign take_ok = selected & (r_q.phase == HB_IDLE) & ~busy;
    assign wr_take = take_ok & stb_rise[HB_STB_WR];
    assign rd_take = take_ok & stb_rise[HB_STB_RD] & dc;

    hb_busy_timer #(.HOLD(BUSY_CYC)) busy_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_take),
        .busy  (busy)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            HB_IDLE: begin
                if (wr_take) begin
                    if (dc) begin
                        r_d.holder = db_in;
                        r_d.phase  = HB_COMMIT;
                    end else if (db_in[FLAG_BIT]) begin
                        r_d.addr = db_in[ADDR_W-1:0];
                    end
                end else if (rd_take) begin
                    r_d.phase = HB_FETCH;
                end
            end
            HB_COMMIT: begin
                r_d.addr  = r_q.addr + ADDR_W'(1);
                r_d.phase = HB_IDLE;
            end
            HB_FETCH: begin
                r_d.phase = HB_CAPTURE;
            end
            HB_CAPTURE: begin
                r_d.holder = ram_rdata;
                r_d.addr   = r_q.addr + ADDR_W'(1);
                r_d.phase  = HB_IDLE;
            end
            default: r_d.phase = HB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase  <= HB_IDLE;
            r_q.holder <= '0;
            r_q.addr   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    logic [DATA_W-1:0] status_byte;
    always_comb begin
        status_byte           = '0;
        status_byte[FLAG_BIT] = busy;
    end

    assign db_oe     = selected & ~rd_n;
    assign db_out    = dc ? r_q.holder : status_byte;
    assign ram_addr  = r_q.addr;
    assign ram_we    = (r_q.phase == HB_COMMIT);
    assign ram_re    = (r_q.phase == HB_FETCH);
    assign ram_wdata = r_q.holder;
endmodule

// File: rtl/hb_host_port_chk.sv
module hb_host_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_a_n,
    input logic              cs_b,
    input logic              dc,
    input logic              rd_n,
    input logic              wr_n,
    input logic [DATA_W-1:0] db_out,
    input logic              db_oe,
    input logic              busy,
    input logic              ram_we,
    input logic              ram_re
);
    logic sel;
    assign sel = ~cs_a_n & cs_b;

    // R1
    a_r1_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !db_oe);

    // R2
    a_r2_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rd_n) |-> db_oe);

    // R9
    a_r9_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R9
    a_r9_we_follows_wr_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(wr_n) && !$past(wr_n, 2)));

    // R7
    a_r7_busy_during_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);

    // R8
    a_r8_no_fetch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |-> !busy);

    // R4
    a_r4_re_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> !ram_re);

    // R7
    a_r7_status_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rd_n && !dc) |-> (db_out[DATA_W-1] == busy &&
                                   db_out[DATA_W-2:0] == '0));

    // R3
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));
endmodule

bind hb_host_port hb_host_port_chk #(.DATA_W(DATA_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_a_n (cs_a_n),
    .cs_b   (cs_b),
    .dc     (dc),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .db_out (db_out),
    .db_oe  (db_oe),
    .busy   (busy),
    .ram_we (ram_we),
    .ram_re (ram_re)
);

// File: tb/hb_host_port_tb_top.sv
module hb_host_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int BUSY_CYC   = 3;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int GAP        = BUSY_CYC + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_a_n = 1'b1, cs_b = 1'b0, dc = 1'b1;
    logic              rd_n = 1'b1, wr_n = 1'b1;
    logic [DATA_W-1:0] db_in = '0;
    logic [DATA_W-1:0] db_out;
    logic              db_oe, busy, ram_we, ram_re;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_host_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .dc(dc),
        .rd_n(rd_n), .wr_n(wr_n), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
        .busy(busy), .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_rdata(ram_rdata)
    );

    // Bench-side display RAM, one cycle read latency
    logic [DATA_W-1:0] ram_mem [DEPTH];
    int we_pulses = 0;
    always @(posedge clk) begin
        if (ram_we) begin
            ram_mem[ram_addr] <= ram_wdata;
            we_pulses <= we_pulses + 1;
        end
        if (ram_re) ram_rdata <= ram_mem[ram_addr];
    end

    // Reference model
    logic [DATA_W-1:0] m_mem [DEPTH];
    logic [DATA_W-1:0] m_hold = '0;
    logic [ADDR_W-1:0] m_addr = '0;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    function automatic logic [DATA_W-1:0] init_byte(int i);
        return DATA_W'(i * 7 + 3);
    endfunction

    function automatic void m_write(logic [DATA_W-1:0] d);
        m_hold = d;
        m_mem[m_addr] = d;
        m_addr = m_addr + ADDR_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] m_read();
        logic [DATA_W-1:0] r;
        r = m_hold;
        m_hold = m_mem[m_addr];
        m_addr = m_addr + ADDR_W'(1);
        return r;
    endfunction

    function automatic void m_cmd(logic [DATA_W-1:0] c);
        if (c[DATA_W-1]) m_addr = c[ADDR_W-1:0];
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_write(logic d_c, logic [DATA_W-1:0] d, int hold);
        @(negedge clk);
        cs_a_n = 1'b0; cs_b = 1'b1; dc = d_c; db_in = d; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic do_read(logic d_c, output logic [DATA_W-1:0] got);
        @(negedge clk);
        cs_a_n = 1'b0; cs_b = 1'b1; dc = d_c; rd_n = 1'b0;
        @(negedge clk);
        got = db_out;
        check("R2 oe during read", {31'd0, db_oe}, 32'd1);
        rd_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [DATA_W-1:0] got, exp;
        int we_before;
        for (int i = 0; i < DEPTH; i++) begin
            ram_mem[i] = init_byte(i);
            m_mem[i]   = init_byte(i);
        end
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 busy", {31'd0, busy}, 32'd0);
        check("R11 oe", {31'd0, db_oe}, 32'd0);
        check("R11 we/re", {30'd0, ram_we, ram_re}, 32'd0);

        // R11 / R4: holder starts 0, address 0
        do_read(1'b1, got); exp = m_read();
        check("R11 holder zero", got, 32'd0);
        do_read(1'b1, got); exp = m_read();
        check("R11 addr zero", got, init_byte(0));

        // R6 address set, R4 dummy then real
        do_write(1'b0, 8'h85, 1); m_cmd(8'h85);
        do_read(1'b1, got); exp = m_read();
        check("R4 dummy read", got, exp);
        do_read(1'b1, got); exp = m_read();
        check("R4 second read", got, init_byte(5));

        // R6 non-address command leaves address alone
        do_write(1'b0, 8'h12, 1); m_cmd(8'h12);
        do_read(1'b1, got); exp = m_read();
        check("R6 plain cmd", got, exp);

        // R3 / R5 write then read back
        do_write(1'b0, 8'h82, 1); m_cmd(8'h82);
        do_write(1'b1, 8'hC3, 1); m_write(8'hC3);
        do_read(1'b1, got); exp = m_read();
        check("R5 read after write", got, 32'hC3);
        do_write(1'b0, 8'h82, 1); m_cmd(8'h82);
        do_read(1'b1, got); exp = m_read();
        do_read(1'b1, got); exp = m_read();
        check("R3 committed byte", got, 32'hC3);

        // R7 / R8 busy window, status read, rejected write
        do_write(1'b0, 8'h8A, 1); m_cmd(8'h8A);
        @(negedge clk);
        dc = 1'b1; db_in = 8'h3C; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        check("R7 busy cycle 1", {31'd0, busy}, 32'd1);
        wr_n = 1'b0; db_in = 8'h99;
        @(negedge clk);
        check("R7 busy cycle 2", {31'd0, busy}, 32'd1);
        wr_n = 1'b1; dc = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        check("R7 busy cycle 3", {31'd0, busy}, 32'd1);
        check("R8 status while busy", {24'd0, db_out}, 32'h80);
        rd_n = 1'b1;
        @(negedge clk);
        check("R7 busy ends", {31'd0, busy}, 32'd0);
        m_write(8'h3C);
        repeat (GAP) @(negedge clk);
        do_read(1'b1, got); exp = m_read();
        check("R8 ignored write holder", got, 32'h3C);
        do_read(1'b1, got); exp = m_read();
        check("R8 ignored write addr", got, exp);

        // R1 deselected accesses
        @(negedge clk);
        cs_b = 1'b0; rd_n = 1'b0; dc = 1'b1;
        @(negedge clk);
        check("R1 oe when deselected", {31'd0, db_oe}, 32'd0);
        rd_n = 1'b1;
        repeat (GAP) @(negedge clk);
        we_before = we_pulses;
        @(negedge clk);
        cs_b = 1'b1; cs_a_n = 1'b1; dc = 1'b1; db_in = 8'h77; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        repeat (GAP) @(negedge clk);
        check("R1 write ignored", we_pulses - we_before, 0);
        do_read(1'b1, got); exp = m_read();
        check("R1 holder kept", got, exp);

        // R9 long strobe: one commit only
        we_before = we_pulses;
        @(negedge clk);
        cs_a_n = 1'b0; cs_b = 1'b1; dc = 1'b1; db_in = 8'h5A; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 no commit while low", we_pulses - we_before, 0);
        wr_n = 1'b1;
        repeat (GAP) @(negedge clk);
        m_write(8'h5A);
        check("R9 single commit", we_pulses - we_before, 1);

        // R10 wrap
        do_write(1'b0, 8'h8F, 1); m_cmd(8'h8F);
        do_write(1'b1, 8'hE1, 1); m_write(8'hE1);
        do_write(1'b1, 8'hE2, 1); m_write(8'hE2);
        do_write(1'b0, 8'h80, 1); m_cmd(8'h80);
        do_read(1'b1, got); exp = m_read();
        do_read(1'b1, got); exp = m_read();
        check("R10 wrap to zero", got, 32'hE2);

        // Random traffic
        for (int k = 0; k < 300; k++) begin
            int op;
            logic [DATA_W-1:0] v;
            op = $urandom_range(0, 3);
            v  = DATA_W'($urandom);
            case (op)
                0: begin do_write(1'b1, v, $urandom_range(1, 3)); m_write(v); end
                1: begin
                    do_read(1'b1, got); exp = m_read();
                    check("R4 random read", got, exp);
                end
                2: begin do_write(1'b0, v, 1); m_cmd(v); end
                default: begin
                    do_read(1'b0, got);
                    check("R7 idle status", got, 32'h00);
                end
            endcase
        end

        done = 1'b1;
        finish_run();
    end
endmodule